// File: doc/BRIEF.md
# Exception entry controller

This block is the entry side of the exception logic in the system-control coprocessor of a 32-bit RISC core with branch delay slots. The pipeline hands it a single-cycle request that carries the kind of fault, the PC of the faulting instruction, the PC that would have followed it, the bad virtual address, the TLB page tag (VPN2 and ASID) and, for unusable-coprocessor faults, the coprocessor number. On the clock edge that accepts the request, the block updates all of its state together. That state is the exception-level flag, the exception PC, the cause fields (code, delay-slot flag, coprocessor number), the bad-address register, the TLB tag registers and the shadow register set selectors. On the same edge it loads the handler address and the two sequential addresses after it into the fetch PC outputs.

A reset request loads the boot vector into the fetch PCs and marks floating-point coprocessor 1 as usable. If a reset request and an exception request arrive in the same cycle, the reset request wins. In the cycle after any accepted request, a redirect strobe tells fetch to flush and restart at the new PC.

The small sequencer has three states. SEQ_IDLE means no redirect is pending. SEQ_TAKEN means an exception was accepted on the last edge. SEQ_BOOT means a reset request was accepted on the last edge. Every state moves the same way: to SEQ_BOOT on a reset request, otherwise to SEQ_TAKEN on an exception request, otherwise to SEQ_IDLE. The redirect strobe is high in SEQ_TAKEN and SEQ_BOOT.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Every accepted exception sets st_exl to 1, even when it is already 1. A pulse on exl_clr in a cycle with no request clears st_exl on the next edge.
- R2: When exc_npc differs from exc_pc+4, epc becomes exc_pc-4 and cause_bd becomes 1. Otherwise epc becomes exc_pc and cause_bd becomes 0.
- R3: The exc_type encoding and the cause_code written for each type are as follows: 0 interrupt→0x0, 1 TLB modified→0x1, 2 TLB refill on load/fetch→0x2, 3 TLB invalid on load/fetch→0x2, 4 TLB refill on store→0x3, 5 TLB invalid on store→0x3, 6 address error on load→0x4, 7 address error on store→0x5, 8 syscall→0x8, 9 breakpoint→0x9, 10 reserved instruction→0xA, 11 coprocessor unusable→0xB, 12 overflow→0xC, 13 trap→0xD.
- R4: cause_ce is cleared on every exception, except type 11, which loads exc_cpid into it.
- R5: If st_exl and cfg_bev are both 0 before the exception, srs_pss takes the old srs_css and srs_css takes cfg_ess. Otherwise both stay unchanged.
- R6: All types not named in R7 to R9 vector to cfg_ebase+0x180.
- R7: TLB refill types (2, 4) vector to cfg_ebase+0x000 if st_exl was 0 before the exception, and to cfg_ebase+0x180 if it was 1.
- R8: An interrupt (type 0) vectors to cfg_ebase+0x200 when cfg_iv is 1 and to cfg_ebase+0x180 when cfg_iv is 0.
- R9: Overflow (type 12) vectors to 0xBFC00200 when cfg_bev is 1, and to cfg_ebase+0x180 when cfg_bev is 0.
- R10: Types 1 to 7 load badvaddr from exc_badva, and the other types leave it unchanged. Types 1 to 5 also load hi_vpn2 and ctx_badvpn2 from exc_vpn2, and hi_asid from exc_asid; the other types leave these unchanged.
- R11: For handler address H, the outputs are fetch_pc=H, fetch_npc=H+4 and fetch_nnpc=H+8 after the accepting edge. redirect is 1 for exactly the cycle after each accepted request.
- R12: A reset request sets the fetch PCs to 0xBFC00000, 0xBFC00004 and 0xBFC00008 and sets st_cu1 to 1. An exception request in the same cycle is ignored: epc, cause, bad-address, TLB tag, shadow-set and st_exl outputs keep their values.
- R13: While rst_n is low, all register outputs are 0, the fetch PCs hold 0xBFC00000 and its two successors, and redirect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset request pulse |
| exc_req | input | 1 | Exception request pulse |
| exc_type | input | 4 | Fault kind, encoded as in R3 |
| exc_pc | input | ADDR_W | PC of the faulting instruction |
| exc_npc | input | ADDR_W | PC that would have followed it |
| exc_badva | input | ADDR_W | Faulting virtual address |
| exc_vpn2 | input | VPN2_W | TLB page tag of the fault |
| exc_asid | input | ASID_W | Address space ID of the fault |
| exc_cpid | input | CE_W | Coprocessor number for type 11 |
| cfg_bev | input | 1 | Boot exception vector mode |
| cfg_iv | input | 1 | Dedicated interrupt vector enable |
| cfg_ebase | input | ADDR_W | Exception base address |
| cfg_ess | input | SRS_W | Shadow set used for exceptions |
| exl_clr | input | 1 | Clears the exception level when no request is present |
| st_exl | output | 1 | Exception level flag |
| st_cu1 | output | 1 | Coprocessor 1 usable |
| epc | output | ADDR_W | Exception return PC |
| cause_code | output | 5 | Exception code |
| cause_bd | output | 1 | Fault was in a delay slot |
| cause_ce | output | CE_W | Coprocessor number of last fault |
| badvaddr | output | ADDR_W | Bad virtual address |
| hi_vpn2 | output | VPN2_W | TLB tag page number |
| hi_asid | output | ASID_W | TLB tag address space ID |
| ctx_badvpn2 | output | VPN2_W | Page number in the context register |
| srs_css | output | SRS_W | Current shadow set |
| srs_pss | output | SRS_W | Previous shadow set |
| fetch_pc | output | ADDR_W | New PC |
| fetch_npc | output | ADDR_W | New next PC |
| fetch_nnpc | output | ADDR_W | New next-next PC |
| redirect | output | 1 | Fetch redirect strobe |

## Verification
The bench uses the default parameters: 32-bit addresses, a 19-bit page tag, an 8-bit ASID, 4-bit shadow-set numbers and a 2-bit coprocessor field. These widths let it check the fixed boot and overflow vectors exactly, and let random shadow-set values expose a wrong PSS/CSS copy. Randomly chosen EBase values and next PCs, sometimes sequential and sometimes not, are mixed with exl_clr pulses and changes to BEV and IV. Together these reach every vector choice, including refill with the flag set and with it clear. Directed cases cover a reset request and an exception request in the same cycle, a repeated exception while the flag is already set, and redirect dropping in an idle cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        EK_INT      = 4'd0,
        EK_TLBMOD   = 4'd1,
        EK_TLBL_RF  = 4'd2,
        EK_TLBL_INV = 4'd3,
        EK_TLBS_RF  = 4'd4,
        EK_TLBS_INV = 4'd5,
        EK_ADEL     = 4'd6,
        EK_ADES     = 4'd7,
        EK_SYS      = 4'd8,
        EK_BRK      = 4'd9,
        EK_RSV      = 4'd10,
        EK_CPU      = 4'd11,
        EK_OVF      = 4'd12,
        EK_TRAP     = 4'd13,
        EK_NA14     = 4'd14,
        EK_NA15     = 4'd15
    } exc_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TAKEN = 2'd1,
        SEQ_BOOT  = 2'd2
    } seq_state_e;

    localparam int CODE_W = 5;

    function automatic logic [CODE_W-1:0] kind_code(exc_kind_e k);
        logic [CODE_W-1:0] c;
        unique case (k)
            EK_INT:                  c = 5'h00;
            EK_TLBMOD:               c = 5'h01;
            EK_TLBL_RF, EK_TLBL_INV: c = 5'h02;
            EK_TLBS_RF, EK_TLBS_INV: c = 5'h03;
            EK_ADEL:                 c = 5'h04;
            EK_ADES:                 c = 5'h05;
            EK_SYS:                  c = 5'h08;
            EK_BRK:                  c = 5'h09;
            EK_RSV:                  c = 5'h0A;
            EK_CPU:                  c = 5'h0B;
            EK_OVF:                  c = 5'h0C;
            default:                 c = 5'h0D;
        endcase
        return c;
    endfunction

    function automatic logic kind_is_tlb(exc_kind_e k);
        return (k >= EK_TLBMOD) && (k <= EK_TLBS_INV);
    endfunction

    function automatic logic kind_has_badva(exc_kind_e k);
        return (k >= EK_TLBMOD) && (k <= EK_ADES);
    endfunction

    function automatic logic kind_is_refill(exc_kind_e k);
        return (k == EK_TLBL_RF) || (k == EK_TLBS_RF);
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] OFF_GEN    = 32'h0000_0180,
    parameter logic [31:0] OFF_IRQ    = 32'h0000_0200,
    parameter logic [31:0] BEV_OV_VEC = 32'hBFC0_0200
) (
    input  exc_kind_e           kind,
    input  logic                exl_before,
    input  logic                bev,
    input  logic                iv,
    input  logic [ADDR_W-1:0]   ebase,
    output logic [ADDR_W-1:0]   handler
);
    localparam logic [ADDR_W-1:0] GEN_OFS = ADDR_W'(OFF_GEN);
    localparam logic [ADDR_W-1:0] IRQ_OFS = ADDR_W'(OFF_IRQ);
    localparam logic [ADDR_W-1:0] OV_VEC  = ADDR_W'(BEV_OV_VEC);

    always_comb begin
        handler = ebase + GEN_OFS;
        if (kind_is_refill(kind)) begin
            handler = exl_before ? (ebase + GEN_OFS) : ebase;
        end else if (kind == EK_INT) begin
            handler = iv ? (ebase + IRQ_OFS) : (ebase + GEN_OFS);
        end else if (kind == EK_OVF) begin
            handler = bev ? OV_VEC : (ebase + GEN_OFS);
        end
    end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req,
    input  logic exc_req,
    output logic take_rst,
    output logic take_exc,
    output logic redirect
);
    seq_state_e state_q, state_d;

    assign take_rst = reset_req;
    assign take_exc = exc_req && !reset_req;

    always_comb begin
        unique case (state_q)
            SEQ_IDLE, SEQ_TAKEN, SEQ_BOOT: begin
                if (reset_req)    state_d = SEQ_BOOT;
                else if (exc_req) state_d = SEQ_TAKEN;
                else              state_d = SEQ_IDLE;
            end
            default:              state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEQ_TAKEN, SEQ_BOOT: redirect = 1'b1;
            default:             redirect = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_pc_gen.sv
module exc_pc_gen #(
    parameter int          ADDR_W     = 32,
    parameter int          INSN_BYTES = 4,
    parameter int          NUM_PC     = 3,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take_rst,
    input  logic                       take_exc,
    input  logic [ADDR_W-1:0]          handler,
    output logic [NUM_PC-1:0][ADDR_W-1:0] pcs
);
    localparam logic [ADDR_W-1:0] BOOT = ADDR_W'(RESET_VEC);

    logic [ADDR_W-1:0] base;
    assign base = take_rst ? BOOT : handler;

    for (genvar g = 0; g < NUM_PC; g++) begin : g_pc
        localparam logic [ADDR_W-1:0] STEP = ADDR_W'(g * INSN_BYTES);
        always_ff @(posedge clk) begin
            if (!rst_n)                    pcs[g] <= BOOT + STEP;
            else if (take_rst || take_exc) pcs[g] <= base + STEP;
        end
    end
endmodule

// File: rtl/exc_cp0_regs.sv
module exc_cp0_regs
    import exc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int VPN2_W     = 19,
    parameter int ASID_W     = 8,
    parameter int SRS_W      = 4,
    parameter int CE_W       = 2,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_rst,
    input  logic               take_exc,
    input  logic               exl_clr,
    input  exc_kind_e          kind,
    input  logic [ADDR_W-1:0]  exc_pc,
    input  logic [ADDR_W-1:0]  exc_npc,
    input  logic [ADDR_W-1:0]  exc_badva,
    input  logic [VPN2_W-1:0]  exc_vpn2,
    input  logic [ASID_W-1:0]  exc_asid,
    input  logic [CE_W-1:0]    exc_cpid,
    input  logic               cfg_bev,
    input  logic [SRS_W-1:0]   cfg_ess,
    output logic               st_exl,
    output logic               st_cu1,
    output logic [ADDR_W-1:0]  epc,
    output logic [CODE_W-1:0]  cause_code,
    output logic               cause_bd,
    output logic [CE_W-1:0]    cause_ce,
    output logic [ADDR_W-1:0]  badvaddr,
    output logic [VPN2_W-1:0]  hi_vpn2,
    output logic [ASID_W-1:0]  hi_asid,
    output logic [VPN2_W-1:0]  ctx_badvpn2,
    output logic [SRS_W-1:0]   srs_css,
    output logic [SRS_W-1:0]   srs_pss
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic in_slot;
    assign in_slot = (exc_pc + STEP) != exc_npc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_exl      <= 1'b0;
            st_cu1      <= 1'b0;
            epc         <= '0;
            cause_code  <= '0;
            cause_bd    <= 1'b0;
            cause_ce    <= '0;
            badvaddr    <= '0;
            hi_vpn2     <= '0;
            hi_asid     <= '0;
            ctx_badvpn2 <= '0;
            srs_css     <= '0;
            srs_pss     <= '0;
        end else if (take_rst) begin
            st_cu1 <= 1'b1;
        end else if (take_exc) begin
            st_exl     <= 1'b1;
            epc        <= in_slot ? (exc_pc - STEP) : exc_pc;
            cause_bd   <= in_slot;
            cause_code <= kind_code(kind);
            cause_ce   <= (kind == EK_CPU) ? exc_cpid : '0;
            if (kind_has_badva(kind)) begin
                badvaddr <= exc_badva;
            end
            if (kind_is_tlb(kind)) begin
                hi_vpn2     <= exc_vpn2;
                hi_asid     <= exc_asid;
                ctx_badvpn2 <= exc_vpn2;
            end
            if (!st_exl && !cfg_bev) begin
                srs_pss <= srs_css;
                srs_css <= cfg_ess;
            end
        end else if (exl_clr) begin
            st_exl <= 1'b0;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          VPN2_W     = 19,
    parameter int          ASID_W     = 8,
    parameter int          SRS_W      = 4,
    parameter int          CE_W       = 2,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] BEV_OV_VEC = 32'hBFC0_0200,
    parameter logic [31:0] OFF_GEN    = 32'h0000_0180,
    parameter logic [31:0] OFF_IRQ    = 32'h0000_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              exc_req,
    input  logic [3:0]        exc_type,
    input  logic [ADDR_W-1:0] exc_pc,
    input  logic [ADDR_W-1:0] exc_npc,
    input  logic [ADDR_W-1:0] exc_badva,
    input  logic [VPN2_W-1:0] exc_vpn2,
    input  logic [ASID_W-1:0] exc_asid,
    input  logic [CE_W-1:0]   exc_cpid,
    input  logic              cfg_bev,
    input  logic              cfg_iv,
    input  logic [ADDR_W-1:0] cfg_ebase,
    input  logic [SRS_W-1:0]  cfg_ess,
    input  logic              exl_clr,
    output logic              st_exl,
    output logic              st_cu1,
    output logic [ADDR_W-1:0] epc,
    output logic [4:0]        cause_code,
    output logic              cause_bd,
    output logic [CE_W-1:0]   cause_ce,
    output logic [ADDR_W-1:0] badvaddr,
    output logic [VPN2_W-1:0] hi_vpn2,
    output logic [ASID_W-1:0] hi_asid,
    output logic [VPN2_W-1:0] ctx_badvpn2,
    output logic [SRS_W-1:0]  srs_css,
    output logic [SRS_W-1:0]  srs_pss,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] fetch_npc,
    output logic [ADDR_W-1:0] fetch_nnpc,
    output logic              redirect
);
    localparam int NUM_PC = 3;

    exc_kind_e         kind;
    logic              take_rst, take_exc;
    logic [ADDR_W-1:0] handler;
    logic [NUM_PC-1:0][ADDR_W-1:0] pcs;

    assign kind = exc_kind_e'(exc_type);

    exc_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .exc_req   (exc_req),
        .take_rst  (take_rst),
        .take_exc  (take_exc),
        .redirect  (redirect)
    );

    exc_vector_sel #(
        .ADDR_W     (ADDR_W),
        .OFF_GEN    (OFF_GEN),
        .OFF_IRQ    (OFF_IRQ),
        .BEV_OV_VEC (BEV_OV_VEC)
    ) u_vec (
        .kind       (kind),
        .exl_before (st_exl),
        .bev        (cfg_bev),
        .iv         (cfg_iv),
        .ebase      (cfg_ebase),
        .handler    (handler)
    );

    exc_pc_gen #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES),
        .NUM_PC     (NUM_PC),
        .RESET_VEC  (RESET_VEC)
    ) u_pcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_rst (take_rst),
        .take_exc (take_exc),
        .handler  (handler),
        .pcs      (pcs)
    );

    assign fetch_pc   = pcs[0];
    assign fetch_npc  = pcs[1];
    assign fetch_nnpc = pcs[2];

    exc_cp0_regs #(
        .ADDR_W     (ADDR_W),
        .VPN2_W     (VPN2_W),
        .ASID_W     (ASID_W),
        .SRS_W      (SRS_W),
        .CE_W       (CE_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_rst    (take_rst),
        .take_exc    (take_exc),
        .exl_clr     (exl_clr),
        .kind        (kind),
        .exc_pc      (exc_pc),
        .exc_npc     (exc_npc),
        .exc_badva   (exc_badva),
        .exc_vpn2    (exc_vpn2),
        .exc_asid    (exc_asid),
        .exc_cpid    (exc_cpid),
        .cfg_bev     (cfg_bev),
        .cfg_ess     (cfg_ess),
        .st_exl      (st_exl),
        .st_cu1      (st_cu1),
        .epc         (epc),
        .cause_code  (cause_code),
        .cause_bd    (cause_bd),
        .cause_ce    (cause_ce),
        .badvaddr    (badvaddr),
        .hi_vpn2     (hi_vpn2),
        .hi_asid     (hi_asid),
        .ctx_badvpn2 (ctx_badvpn2),
        .srs_css     (srs_css),
        .srs_pss     (srs_pss)
    );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          SRS_W      = 4,
    parameter int          CE_W       = 2,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] BEV_OV_VEC = 32'hBFC0_0200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reset_req,
    input logic              exc_req,
    input logic [3:0]        exc_type,
    input logic [ADDR_W-1:0] exc_pc,
    input logic [ADDR_W-1:0] exc_npc,
    input logic              cfg_bev,
    input logic              st_exl,
    input logic              st_cu1,
    input logic [ADDR_W-1:0] epc,
    input logic [4:0]        cause_code,
    input logic              cause_bd,
    input logic [CE_W-1:0]   cause_ce,
    input logic [SRS_W-1:0]  srs_css,
    input logic [SRS_W-1:0]  srs_pss,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] fetch_npc,
    input logic [ADDR_W-1:0] fetch_nnpc,
    input logic              redirect
);
    logic took;
    assign took = exc_req && !reset_req;

    // R1
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> st_exl);

    // R2
    bd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && (exc_npc != exc_pc + 4)) |=> (cause_bd && epc == $past(exc_pc) - 4));

    // R2
    bd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && (exc_npc == exc_pc + 4)) |=> (!cause_bd && epc == $past(exc_pc)));

    // R4
    ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && exc_type != 4'd11) |=> (cause_ce == '0));

    // R5
    srs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && (st_exl || cfg_bev)) |=> ($stable(srs_css) && $stable(srs_pss)));

    // R9
    ovf_bev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && exc_type == 4'd12 && cfg_bev) |=> (fetch_pc == ADDR_W'(BEV_OV_VEC)));

    // R11
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (fetch_npc == fetch_pc + 4 && fetch_nnpc == fetch_pc + 8));

    // R11
    redirect_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || reset_req) |=> redirect);

    // R11
    redirect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req || reset_req) |=> !redirect);

    // R12
    reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (fetch_pc == ADDR_W'(RESET_VEC) && st_cu1));

    // R12
    reset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> ($stable(epc) && $stable(cause_code) && $stable(st_exl)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .ADDR_W     (ADDR_W),
    .SRS_W      (SRS_W),
    .CE_W       (CE_W),
    .RESET_VEC  (RESET_VEC),
    .BEV_OV_VEC (BEV_OV_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_req  (reset_req),
    .exc_req    (exc_req),
    .exc_type   (exc_type),
    .exc_pc     (exc_pc),
    .exc_npc    (exc_npc),
    .cfg_bev    (cfg_bev),
    .st_exl     (st_exl),
    .st_cu1     (st_cu1),
    .epc        (epc),
    .cause_code (cause_code),
    .cause_bd   (cause_bd),
    .cause_ce   (cause_ce),
    .srs_css    (srs_css),
    .srs_pss    (srs_pss),
    .fetch_pc   (fetch_pc),
    .fetch_npc  (fetch_npc),
    .fetch_nnpc (fetch_nnpc),
    .redirect   (redirect)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, reset_req, exc_req, cfg_bev, cfg_iv, exl_clr;
    logic [3:0]  exc_type;
    logic [31:0] exc_pc, exc_npc, exc_badva, cfg_ebase;
    logic [18:0] exc_vpn2;
    logic [7:0]  exc_asid;
    logic [1:0]  exc_cpid;
    logic [3:0]  cfg_ess;

    logic        st_exl, st_cu1, cause_bd, redirect;
    logic [31:0] epc, badvaddr, fetch_pc, fetch_npc, fetch_nnpc;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce;
    logic [18:0] hi_vpn2, ctx_badvpn2;
    logic [7:0]  hi_asid;
    logic [3:0]  srs_css, srs_pss;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .exc_req(exc_req),
        .exc_type(exc_type), .exc_pc(exc_pc), .exc_npc(exc_npc),
        .exc_badva(exc_badva), .exc_vpn2(exc_vpn2), .exc_asid(exc_asid),
        .exc_cpid(exc_cpid), .cfg_bev(cfg_bev), .cfg_iv(cfg_iv),
        .cfg_ebase(cfg_ebase), .cfg_ess(cfg_ess), .exl_clr(exl_clr),
        .st_exl(st_exl), .st_cu1(st_cu1), .epc(epc), .cause_code(cause_code),
        .cause_bd(cause_bd), .cause_ce(cause_ce), .badvaddr(badvaddr),
        .hi_vpn2(hi_vpn2), .hi_asid(hi_asid), .ctx_badvpn2(ctx_badvpn2),
        .srs_css(srs_css), .srs_pss(srs_pss), .fetch_pc(fetch_pc),
        .fetch_npc(fetch_npc), .fetch_nnpc(fetch_nnpc), .redirect(redirect)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state
    logic        m_exl, m_cu1, m_bd;
    logic [31:0] m_epc, m_bva, m_pc;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [18:0] m_vpn2, m_ctx;
    logic [7:0]  m_asid;
    logic [3:0]  m_css, m_pss;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(int t);
        case (t)
            0: return 5'h00;
            1: return 5'h01;
            2, 3: return 5'h02;
            4, 5: return 5'h03;
            6: return 5'h04;
            7: return 5'h05;
            8: return 5'h08;
            9: return 5'h09;
            10: return 5'h0A;
            11: return 5'h0B;
            12: return 5'h0C;
            default: return 5'h0D;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(int t, logic exl0, logic bev, logic iv,
                                            logic [31:0] eb);
        if (t == 2 || t == 4) return exl0 ? eb + 32'h180 : eb;      // R7
        if (t == 0) return iv ? eb + 32'h200 : eb + 32'h180;       // R8
        if (t == 12 && bev) return 32'hBFC00200;                   // R9
        return eb + 32'h180;                                       // R6
    endfunction

    task automatic compare_all(string ctx);
        chk({ctx, " R1 exl"}, 32'(st_exl), 32'(m_exl));
        chk({ctx, " R12 cu1"}, 32'(st_cu1), 32'(m_cu1));
        chk({ctx, " R2 epc"}, epc, m_epc);
        chk({ctx, " R2 bd"}, 32'(cause_bd), 32'(m_bd));
        chk({ctx, " R3 code"}, 32'(cause_code), 32'(m_code));
        chk({ctx, " R4 ce"}, 32'(cause_ce), 32'(m_ce));
        chk({ctx, " R10 badva"}, badvaddr, m_bva);
        chk({ctx, " R10 vpn2"}, 32'(hi_vpn2), 32'(m_vpn2));
        chk({ctx, " R10 asid"}, 32'(hi_asid), 32'(m_asid));
        chk({ctx, " R10 ctx"}, 32'(ctx_badvpn2), 32'(m_ctx));
        chk({ctx, " R5 css"}, 32'(srs_css), 32'(m_css));
        chk({ctx, " R5 pss"}, 32'(srs_pss), 32'(m_pss));
        chk({ctx, " R11 pc"}, fetch_pc, m_pc);
        chk({ctx, " R11 npc"}, fetch_npc, m_pc + 4);
        chk({ctx, " R11 nnpc"}, fetch_nnpc, m_pc + 8);
    endtask

    task automatic model_exc(int t);
        logic slot;
        m_pc = exp_vec(t, m_exl, cfg_bev, cfg_iv, cfg_ebase);
        if (!m_exl && !cfg_bev) begin
            m_pss = m_css;
            m_css = cfg_ess;
        end
        m_exl  = 1'b1;
        slot   = (exc_pc + 4) != exc_npc;
        m_epc  = slot ? exc_pc - 4 : exc_pc;
        m_bd   = slot;
        m_code = exp_code(t);
        m_ce   = (t == 11) ? exc_cpid : 2'd0;
        if (t >= 1 && t <= 7) m_bva = exc_badva;
        if (t >= 1 && t <= 5) begin
            m_vpn2 = exc_vpn2;
            m_asid = exc_asid;
            m_ctx  = exc_vpn2;
        end
    endtask

    // One request cycle; with_rst also raises reset_req.
    task automatic fire(int t, logic [31:0] pc, logic [31:0] npc, logic with_exc,
                        logic with_rst, string ctx);
        @(negedge clk);
        exc_type  = 4'(t);
        exc_pc    = pc;
        exc_npc   = npc;
        exc_badva = $urandom;
        exc_vpn2  = 19'($urandom);
        exc_asid  = 8'($urandom);
        exc_cpid  = 2'($urandom);
        cfg_ess   = 4'($urandom);
        exc_req   = with_exc;
        reset_req = with_rst;
        if (with_rst) begin
            m_cu1 = 1'b1;
            m_pc  = 32'hBFC00000;
        end else if (with_exc) begin
            model_exc(t);
        end
        @(negedge clk);
        exc_req   = 1'b0;
        reset_req = 1'b0;
        compare_all(ctx);
        chk({ctx, " R11 redirect on"}, 32'(redirect), 32'(with_exc | with_rst));
    endtask

    task automatic idle(logic clr);
        @(negedge clk);
        exl_clr = clr;
        if (clr) m_exl = 1'b0;
        @(negedge clk);
        exl_clr = 1'b0;
        chk("R11 redirect off", 32'(redirect), 32'd0);
        chk("R1 exl after clear", 32'(st_exl), 32'(m_exl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; reset_req = 0; exc_req = 0; exl_clr = 0;
        exc_type = 0; exc_pc = 0; exc_npc = 0; exc_badva = 0;
        exc_vpn2 = 0; exc_asid = 0; exc_cpid = 0;
        cfg_bev = 0; cfg_iv = 0; cfg_ebase = 32'h8000_0000; cfg_ess = 0;
        m_exl = 0; m_cu1 = 0; m_bd = 0; m_epc = 0; m_bva = 0; m_code = 0;
        m_ce = 0; m_vpn2 = 0; m_ctx = 0; m_asid = 0; m_css = 0; m_pss = 0;
        m_pc = 32'hBFC00000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R13 reset");
        chk("R13 redirect in reset", 32'(redirect), 32'd0);
        rst_n = 1;

        // R12 reset request
        fire(0, 0, 4, 1'b0, 1'b1, "R12 reset req");
        // R7 refill with EXL 0 then with EXL 1
        cfg_ebase = 32'h8000_1000;
        fire(2, 32'h100, 32'h104, 1'b1, 1'b0, "R7 refill exl0");
        fire(4, 32'h200, 32'h204, 1'b1, 1'b0, "R7 refill exl1");
        // R1 repeated entry with EXL already 1, then clear
        fire(8, 32'h300, 32'h304, 1'b1, 1'b0, "R1 exl again");
        idle(1'b1);
        // R2 delay slot
        fire(13, 32'h400, 32'h800, 1'b1, 1'b0, "R2 slot");
        idle(1'b1);
        // R8 interrupt with IV
        cfg_iv = 1;
        fire(0, 32'h500, 32'h504, 1'b1, 1'b0, "R8 iv1");
        idle(1'b1);
        cfg_iv = 0;
        fire(0, 32'h500, 32'h504, 1'b1, 1'b0, "R8 iv0");
        idle(1'b1);
        // R9 overflow with BEV, R5 no switch under BEV
        cfg_bev = 1;
        fire(12, 32'h600, 32'h604, 1'b1, 1'b0, "R9 ovf bev1");
        idle(1'b1);
        cfg_bev = 0;
        fire(12, 32'h600, 32'h604, 1'b1, 1'b0, "R9 ovf bev0");
        // R4 coprocessor unusable
        fire(11, 32'h700, 32'h704, 1'b1, 1'b0, "R4 cpu");
        idle(1'b1);
        // R12 collision: reset wins, exception ignored
        fire(1, 32'h900, 32'hA00, 1'b1, 1'b1, "R12 collision");
        idle(1'b0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int t;
            logic [31:0] pc, npc;
            t   = $urandom_range(0, 13);
            pc  = $urandom & 32'hFFFF_FFFC;
            npc = $urandom_range(0, 1) ? pc + 4 : ($urandom & 32'hFFFF_FFFC);
            cfg_bev   = ($urandom_range(0, 3) == 0);
            cfg_iv    = $urandom_range(0, 1);
            cfg_ebase = $urandom & 32'hFFFF_F000;
            if ($urandom_range(0, 9) == 0)
                fire(t, pc, npc, $urandom_range(0, 1), 1'b1, "R12 rand reset");
            else
                fire(t, pc, npc, 1'b1, 1'b0, "R3 R6 R10 rand exc");
            if ($urandom_range(0, 2) == 0) idle($urandom_range(0, 1));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule